// File: doc/BRIEF.md
# DMA Activation Request Router

This block sits between the interrupt sources of a microcontroller's peripherals and a four-channel DMA engine. It decides, channel by channel, whether a peripheral event should start a DMA transfer, and it issues grants to the engine one at a time. It also decides whether that event should instead be forwarded as an ordinary interrupt to the processor and its transfer-assist path. Each channel carries a source selector, a transfer-mode field, an enable bit and an ownership bit. The ownership bit says whether the DMA side alone consumes the source or shares it with interrupt handling.

Requests may come from eleven internal interrupt flags: one conversion-complete, two transmit-ready, two receive-ready and six timer-compare. They may also come from two active-low external request pins, sampled either by falling edge or by low level, or from a free-running auto-request. Each channel latches its requests as a pending bit. A fixed-priority arbiter grants one channel and holds the grant until the DMA engine reports the end of that transfer. The block then pulses a flag-clear strobe back to the peripheral when the rules allow it. Bus cycles, address generation and interrupt-priority logic live elsewhere.

Top module: `dma_act_router`

## Requirements
- R1: While reset is high and on the first cycle after it, `grant`, `flag_clr` and `cpu_irq` are all zero.
- R2: Selector codes are 0 = conversion-complete, 1/2 = transmit/receive of serial port 0, 3/4 = transmit/receive of serial port 1, 5..10 = timer compares 0..5, 11 = external pin falling edge, 12 = external pin low level, 13 = auto-request, 14/15 = reserved. Mode codes are 0 = short (codes 0..10 on any channel), 1 = full-normal (codes 11..13, even channels only), 2 = full-block (codes 0..12, even channels only), 3 = reserved. Any other combination is illegal: the channel never requests and is not counted as owning a source.
- R3: A 0-to-1 change of an internal flag that an enabled channel legally selects latches a pending bit in every such channel on the next edge. The grant appears one edge later. A flag that stays high does not request again.
- R4: `grant` is one-hot or zero. The lowest-numbered channel that is pending and enabled wins. A grant holds until it is released, and at least one cycle with no grant separates two grants.
- R5: `xfer_done` of the granted channel drops `grant` and that channel's pending bit on the next edge. `xfer_done` of any other channel has no effect.
- R6: When a channel's enable is 0, its pending bit is cleared, its grant is withdrawn on the next edge, and its source is not treated as owned.
- R7: `cpu_irq[s]` follows `src_flag[s]` one edge later, except while some enabled channel with ownership 1 legally selects source s. In that case it is 0.
- R8: For timer sources (codes 5..10), completion of a grant on an owning channel that leads the source pulses `flag_clr` for that source for one cycle, one edge after `xfer_done`.
- R9: For codes 0..4, the clear pulse of R8 happens only if `reg_hit` of that channel is 1 together with `xfer_done`.
- R10: A channel with ownership 0 never causes a `flag_clr` pulse.
- R11: When several enabled channels legally select one source, only the lowest-numbered of them (the leader) can clear its flag. The others keep their pending requests and are granted afterwards in priority order.
- R12: External pin 0 serves channels 0 and 1, and pin 1 serves channels 2 and 3. Each pin passes two synchronizing stages. In edge mode, each high-to-low transition latches exactly one request, and a grant follows on the fourth edge after the pin falls.
- R13: In level mode, the channel requests on every cycle while the synchronized pin is low, so it is granted again after each completion.
- R14: Auto-request keeps the channel pending on every cycle while it is enabled. The first grant comes two edges after the enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_flag | input | 11 | Internal interrupt flags, index = selector code 0..10 |
| ch_src_sel | input | 4*NUM_CH | Per-channel source selector, channel c at bits [4c+3:4c] |
| ch_mode | input | 2*NUM_CH | Per-channel transfer mode, channel c at bits [2c+1:2c] |
| ch_enable | input | NUM_CH | Per-channel enable |
| ch_own | input | NUM_CH | Per-channel ownership (1 = DMA side may clear the flag) |
| dreq_n | input | NUM_CH/2 | Active-low external request pins |
| xfer_done | input | NUM_CH | Per-channel end-of-transfer strobe |
| reg_hit | input | NUM_CH | Transfer touched the peripheral's designated register |
| grant | output | NUM_CH | One-hot transfer grant, registered |
| flag_clr | output | 11 | One-cycle flag-clear pulses, registered |
| cpu_irq | output | 11 | Interrupt requests forwarded to the processor side, registered |

## Verification
A pending bit that sets wrongly shows up as a grant two edges after the stimulus. Every state element sits at most two registers from an output, so a corrupted synchronizer stage is visible no later than the fourth edge. A wrong leader or ownership decision appears as a missing or extra `flag_clr` pulse exactly one edge after `xfer_done`. A lost latch on a shared source appears as a lower channel that is never granted after the leader finishes. A wrong ownership map appears as a `cpu_irq` bit that does not follow its flag one edge later.

// File: rtl/dmarr_pkg.sv
package dmarr_pkg;
  localparam int SEL_W       = 4;
  localparam int MODE_W      = 2;
  localparam int NUM_INT     = 11;
  localparam int NUM_HIT_SRC = 5;

  localparam logic [SEL_W-1:0] SEL_PIN_EDGE  = 4'd11;
  localparam logic [SEL_W-1:0] SEL_PIN_LEVEL = 4'd12;
  localparam logic [SEL_W-1:0] SEL_AUTO      = 4'd13;

  typedef enum logic [MODE_W-1:0] {
    MODE_SHORT       = 2'd0,
    MODE_FULL_NORMAL = 2'd1,
    MODE_FULL_BLOCK  = 2'd2,
    MODE_RSVD        = 2'd3
  } xfer_mode_e;

  // Source legality per channel side and mode
  function automatic logic sel_legal(input logic [SEL_W-1:0] sel,
                                     input logic [MODE_W-1:0] mode,
                                     input logic even_side);
    logic is_int;
    logic is_pin;
    is_int = (sel < SEL_W'(NUM_INT));
    is_pin = (sel == SEL_PIN_EDGE) || (sel == SEL_PIN_LEVEL);
    case (xfer_mode_e'(mode))
      MODE_SHORT:       sel_legal = is_int;
      MODE_FULL_NORMAL: sel_legal = even_side && (is_pin || sel == SEL_AUTO);
      MODE_FULL_BLOCK:  sel_legal = even_side && (is_int || is_pin);
      default:          sel_legal = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/dmarr_src_sync.sv
module dmarr_src_sync #(
  parameter int NUM_SRC = 11,
  parameter int NUM_PIN = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_flag,
  input  logic [NUM_PIN-1:0] pin_n,
  output logic [NUM_SRC-1:0] src_rise,
  output logic [NUM_PIN-1:0] pin_fall,
  output logic [NUM_PIN-1:0] pin_low
);
  logic [NUM_SRC-1:0] src_q;

  always_ff @(posedge clk) begin
    if (rst) src_q <= '0;
    else     src_q <= src_flag;
  end

  assign src_rise = src_flag & ~src_q;

  for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
    logic [2:0] shr;
    always_ff @(posedge clk) begin
      if (rst) shr <= 3'b111;
      else     shr <= {shr[1:0], pin_n[p]};
    end
    assign pin_fall[p] = shr[2] & ~shr[1];
    assign pin_low[p]  = ~shr[1];
  end
endmodule

// File: rtl/dmarr_chan_req.sv
module dmarr_chan_req
  import dmarr_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int NUM_PIN = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CH*SEL_W-1:0] ch_src_sel,
  input  logic [NUM_CH*MODE_W-1:0] ch_mode,
  input  logic [NUM_CH-1:0]       ch_enable,
  input  logic [NUM_INT-1:0]      src_rise,
  input  logic [NUM_PIN-1:0]      pin_fall,
  input  logic [NUM_PIN-1:0]      pin_low,
  input  logic [NUM_CH-1:0]       grant,
  input  logic [NUM_CH-1:0]       xfer_done,
  output logic [NUM_CH-1:0]       chan_ok,
  output logic [NUM_CH-1:0]       pend
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int PIN = c / 2;
    logic [SEL_W-1:0]  sel;
    logic [MODE_W-1:0] mode;
    logic              event_hit;
    logic              finish;

    assign sel        = ch_src_sel[c*SEL_W +: SEL_W];
    assign mode       = ch_mode[c*MODE_W +: MODE_W];
    assign chan_ok[c] = ch_enable[c] & sel_legal(sel, mode, (c % 2) == 0);
    assign finish     = grant[c] & xfer_done[c];

    always_comb begin
      event_hit = 1'b0;
      for (int s = 0; s < NUM_INT; s++) begin
        if (sel == SEL_W'(s)) event_hit = src_rise[s];
      end
      if (sel == SEL_PIN_EDGE)  event_hit = pin_fall[PIN];
      if (sel == SEL_PIN_LEVEL) event_hit = pin_low[PIN];
      if (sel == SEL_AUTO)      event_hit = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (rst)              pend[c] <= 1'b0;
      else if (!chan_ok[c]) pend[c] <= 1'b0;
      else                  pend[c] <= (pend[c] & ~finish) | event_hit;
    end
  end
endmodule

// File: rtl/dmarr_arbiter.sv
module dmarr_arbiter #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] pend,
  input  logic [NUM_CH-1:0] chan_ok,
  input  logic [NUM_CH-1:0] xfer_done,
  output logic [NUM_CH-1:0] grant
);
  logic [NUM_CH-1:0] cand;
  logic [NUM_CH-1:0] pick;
  logic              found;
  logic              release_now;

  assign cand        = pend & chan_ok;
  assign release_now = |(grant & (xfer_done | ~chan_ok));

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (cand[c] && !found) begin
        pick[c] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                grant <= '0;
    else if (grant == '0)   grant <= pick;
    else if (release_now)   grant <= '0;
  end
endmodule

// File: rtl/dmarr_flag_ctl.sv
module dmarr_flag_ctl
  import dmarr_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_INT-1:0]      src_flag,
  input  logic [NUM_CH*SEL_W-1:0] ch_src_sel,
  input  logic [NUM_CH-1:0]       chan_ok,
  input  logic [NUM_CH-1:0]       ch_own,
  input  logic [NUM_CH-1:0]       grant,
  input  logic [NUM_CH-1:0]       xfer_done,
  input  logic [NUM_CH-1:0]       reg_hit,
  output logic [NUM_INT-1:0]      flag_clr,
  output logic [NUM_INT-1:0]      cpu_irq
);
  logic [SEL_W-1:0]   sel_a [NUM_CH];
  logic [NUM_CH-1:0]  lead;
  logic [NUM_INT-1:0] clr_n;
  logic [NUM_INT-1:0] owned;

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) sel_a[c] = ch_src_sel[c*SEL_W +: SEL_W];
  end

  // Leader: lowest enabled, legal channel on an internal source
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      lead[c] = chan_ok[c] && (sel_a[c] < SEL_W'(NUM_INT));
      for (int d = 0; d < c; d++) begin
        if (chan_ok[d] && sel_a[d] == sel_a[c]) lead[c] = 1'b0;
      end
    end
  end

  always_comb begin
    for (int s = 0; s < NUM_INT; s++) begin
      clr_n[s] = 1'b0;
      owned[s] = 1'b0;
      for (int c = 0; c < NUM_CH; c++) begin
        if (sel_a[c] == SEL_W'(s)) begin
          if (chan_ok[c] && ch_own[c]) owned[s] = 1'b1;
          if (grant[c] && xfer_done[c] && lead[c] && ch_own[c] &&
              (s >= NUM_HIT_SRC || reg_hit[c]))
            clr_n[s] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_clr <= '0;
      cpu_irq  <= '0;
    end else begin
      flag_clr <= clr_n;
      cpu_irq  <= src_flag & ~owned;
    end
  end
endmodule

// File: rtl/dma_act_router.sv
module dma_act_router
  import dmarr_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int NUM_PIN = (NUM_CH + 1) / 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_INT-1:0]        src_flag,
  input  logic [NUM_CH*SEL_W-1:0]   ch_src_sel,
  input  logic [NUM_CH*MODE_W-1:0]  ch_mode,
  input  logic [NUM_CH-1:0]         ch_enable,
  input  logic [NUM_CH-1:0]         ch_own,
  input  logic [NUM_PIN-1:0]        dreq_n,
  input  logic [NUM_CH-1:0]         xfer_done,
  input  logic [NUM_CH-1:0]         reg_hit,
  output logic [NUM_CH-1:0]         grant,
  output logic [NUM_INT-1:0]        flag_clr,
  output logic [NUM_INT-1:0]        cpu_irq
);
  logic [NUM_INT-1:0] src_rise;
  logic [NUM_PIN-1:0] pin_fall;
  logic [NUM_PIN-1:0] pin_low;
  logic [NUM_CH-1:0]  chan_ok;
  logic [NUM_CH-1:0]  pend;

  dmarr_src_sync #(.NUM_SRC(NUM_INT), .NUM_PIN(NUM_PIN)) u_sync (
    .clk(clk), .rst(rst), .src_flag(src_flag), .pin_n(dreq_n),
    .src_rise(src_rise), .pin_fall(pin_fall), .pin_low(pin_low)
  );

  dmarr_chan_req #(.NUM_CH(NUM_CH), .NUM_PIN(NUM_PIN)) u_req (
    .clk(clk), .rst(rst), .ch_src_sel(ch_src_sel), .ch_mode(ch_mode),
    .ch_enable(ch_enable), .src_rise(src_rise), .pin_fall(pin_fall),
    .pin_low(pin_low), .grant(grant), .xfer_done(xfer_done),
    .chan_ok(chan_ok), .pend(pend)
  );

  dmarr_arbiter #(.NUM_CH(NUM_CH)) u_arb (
    .clk(clk), .rst(rst), .pend(pend), .chan_ok(chan_ok),
    .xfer_done(xfer_done), .grant(grant)
  );

  dmarr_flag_ctl #(.NUM_CH(NUM_CH)) u_flag (
    .clk(clk), .rst(rst), .src_flag(src_flag), .ch_src_sel(ch_src_sel),
    .chan_ok(chan_ok), .ch_own(ch_own), .grant(grant),
    .xfer_done(xfer_done), .reg_hit(reg_hit),
    .flag_clr(flag_clr), .cpu_irq(cpu_irq)
  );
endmodule

// File: rtl/dmarr_checker.sv
module dmarr_checker #(
  parameter int NUM_CH  = 4,
  parameter int NUM_SRC = 11
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] src_flag,
  input logic [NUM_CH-1:0]  ch_enable,
  input logic [NUM_CH-1:0]  xfer_done,
  input logic [NUM_CH-1:0]  grant,
  input logic [NUM_SRC-1:0] flag_clr,
  input logic [NUM_SRC-1:0] cpu_irq
);
  p_grant_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  p_grant_no_switch_r4: assert property (@(posedge clk) disable iff (rst)
    (grant != '0) |=> (grant == $past(grant) || grant == '0));

  p_done_release_r5: assert property (@(posedge clk) disable iff (rst)
    ((grant & xfer_done) != '0) |=> (grant == '0));

  p_disable_drop_r6: assert property (@(posedge clk) disable iff (rst)
    ((grant & ~ch_enable) != '0) |=> (grant == '0));

  p_clr_after_done_r8: assert property (@(posedge clk) disable iff (rst)
    (flag_clr != '0) |-> $past((grant & xfer_done) != '0));

  p_clr_single_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(flag_clr));

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_fwd
    p_irq_follows_flag_r7: assert property (@(posedge clk) disable iff (rst)
      cpu_irq[s] |-> $past(src_flag[s]));
  end
endmodule

bind dma_act_router dmarr_checker #(.NUM_CH(NUM_CH), .NUM_SRC(dmarr_pkg::NUM_INT)) u_chk (
  .clk(clk), .rst(rst), .src_flag(src_flag), .ch_enable(ch_enable),
  .xfer_done(xfer_done), .grant(grant), .flag_clr(flag_clr), .cpu_irq(cpu_irq)
);

// File: tb/dma_act_router_test.sv
module dma_act_router_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int NSRC = 11;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] src_flag = '0;
  logic [NCH*4-1:0] ch_src_sel = '0;
  logic [NCH*2-1:0] ch_mode = '0;
  logic [NCH-1:0]  ch_enable = '0;
  logic [NCH-1:0]  ch_own = '0;
  logic [1:0]      dreq_n = 2'b11;
  logic [NCH-1:0]  xfer_done = '0;
  logic [NCH-1:0]  reg_hit = '0;
  logic [NCH-1:0]  grant;
  logic [NSRC-1:0] flag_clr;
  logic [NSRC-1:0] cpu_irq;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [NSRC-1:0] m_src_q;
  logic [1:0]      m_p1, m_p2, m_p3;
  logic [NCH-1:0]  m_pend, m_grant;
  logic [NSRC-1:0] m_clr, m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_act_router #(.NUM_CH(NCH)) uut (
    .clk(clk), .rst(rst), .src_flag(src_flag), .ch_src_sel(ch_src_sel),
    .ch_mode(ch_mode), .ch_enable(ch_enable), .ch_own(ch_own),
    .dreq_n(dreq_n), .xfer_done(xfer_done), .reg_hit(reg_hit),
    .grant(grant), .flag_clr(flag_clr), .cpu_irq(cpu_irq)
  );

  function automatic int sel_of(int c);
    return int'(ch_src_sel[c*4 +: 4]);
  endfunction

  function automatic int mode_of(int c);
    return int'(ch_mode[c*2 +: 2]);
  endfunction

  // R2 legality table
  function automatic bit legal_f(int sel, int mode, int c);
    bit even = (c % 2 == 0);
    if (mode == 0) return sel <= 10;
    if (mode == 1) return even && sel >= 11 && sel <= 13;
    if (mode == 2) return even && sel <= 12;
    return 1'b0;
  endfunction

  task automatic model_step();
    logic [NSRC-1:0] rise, clr_n, own_n;
    logic [1:0] fall, low;
    logic [NCH-1:0] ok, ev, lead, pick, npend, ngrant;
    bit found;
    if (rst) begin
      m_src_q = '0; m_p1 = 2'b11; m_p2 = 2'b11; m_p3 = 2'b11;
      m_pend = '0; m_grant = '0; m_clr = '0; m_irq = '0;
      return;
    end
    rise = src_flag & ~m_src_q;
    fall = m_p3 & ~m_p2;
    low  = ~m_p2;
    for (int c = 0; c < NCH; c++) begin
      int s = sel_of(c);
      ok[c] = ch_enable[c] && legal_f(s, mode_of(c), c);
      if (s <= 10)      ev[c] = rise[s];
      else if (s == 11) ev[c] = fall[c/2];
      else if (s == 12) ev[c] = low[c/2];
      else              ev[c] = (s == 13);
      npend[c] = ok[c] ? ((m_pend[c] && !(m_grant[c] && xfer_done[c])) || ev[c]) : 1'b0;
    end
    pick = '0; found = 0;
    for (int c = 0; c < NCH; c++)
      if (!found && m_pend[c] && ok[c]) begin pick[c] = 1'b1; found = 1; end
    if (m_grant == '0) ngrant = pick;
    else if ((m_grant & (xfer_done | ~ok)) != '0) ngrant = '0;
    else ngrant = m_grant;
    for (int c = 0; c < NCH; c++) begin
      lead[c] = ok[c] && sel_of(c) <= 10;
      for (int d = 0; d < c; d++)
        if (ok[d] && sel_of(d) == sel_of(c)) lead[c] = 1'b0;
    end
    for (int s = 0; s < NSRC; s++) begin
      clr_n[s] = 1'b0; own_n[s] = 1'b0;
      for (int c = 0; c < NCH; c++) if (sel_of(c) == s) begin
        if (ok[c] && ch_own[c]) own_n[s] = 1'b1;
        if (m_grant[c] && xfer_done[c] && lead[c] && ch_own[c] && (s >= 5 || reg_hit[c]))
          clr_n[s] = 1'b1;
      end
    end
    m_clr = clr_n;
    m_irq = src_flag & ~own_n;
    m_pend = npend;
    m_grant = ngrant;
    m_src_q = src_flag;
    m_p3 = m_p2; m_p2 = m_p1; m_p1 = dreq_n;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    model_step();
    chk("R4 grant vs reference", 32'(grant), 32'(m_grant));
    chk("R8 flag_clr vs reference", 32'(flag_clr), 32'(m_clr));
    chk("R7 cpu_irq vs reference", 32'(cpu_irq), 32'(m_irq));
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic cfg(int c, int sel, int mode, bit en, bit own);
    ch_src_sel[c*4 +: 4] = 4'(sel);
    ch_mode[c*2 +: 2] = 2'(mode);
    ch_enable[c] = en;
    ch_own[c] = own;
  endtask

  task automatic idle();
    ch_enable = '0; ch_own = '0; ch_src_sel = '0; ch_mode = '0;
    src_flag = '0; dreq_n = 2'b11; xfer_done = '0; reg_hit = '0;
    ticks(4);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL R4 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    ticks(3);
    chk("R1 grant in reset", 32'(grant), 0);
    chk("R1 flag_clr in reset", 32'(flag_clr), 0);
    rst = 1'b0;
    tick();
    chk("R1 grant after reset", 32'(grant), 0);
    chk("R1 cpu_irq after reset", 32'(cpu_irq), 0);

    // R2 illegal selections
    idle();
    cfg(1, 13, 1, 1, 1); cfg(3, 4, 2, 1, 1); cfg(0, 13, 0, 1, 1); cfg(2, 3, 3, 1, 1);
    src_flag[4] = 1'b1; src_flag[3] = 1'b1;
    ticks(4);
    chk("R2 illegal never granted", 32'(grant), 0);
    chk("R2 illegal does not own", 32'(cpu_irq), 32'h018);

    // R3 R11 shared timer source
    idle();
    cfg(0, 5, 0, 1, 1); cfg(2, 5, 0, 1, 1);
    src_flag[5] = 1'b1;
    ticks(2);
    chk("R3 grant after rise", 32'(grant), 32'h1);
    chk("R7 owned source not forwarded", 32'(cpu_irq), 0);
    xfer_done[0] = 1'b1; tick();
    chk("R8 leader clears timer flag", 32'(flag_clr), 32'h020);
    chk("R5 done releases grant", 32'(grant), 0);
    xfer_done = '0; src_flag[5] = 1'b0; tick();
    chk("R11 lower channel served", 32'(grant), 32'h4);
    xfer_done[2] = 1'b1; tick();
    chk("R11 no clear from non-leader", 32'(flag_clr), 0);
    xfer_done = '0;

    // R9 access-hit sources
    idle();
    cfg(0, 0, 0, 1, 1);
    src_flag[0] = 1'b1; ticks(2);
    chk("R3 conversion grant", 32'(grant), 32'h1);
    xfer_done[0] = 1'b1; tick();
    chk("R9 no clear without reg_hit", 32'(flag_clr), 0);
    xfer_done = '0; ticks(2);
    chk("R3 held flag does not re-request", 32'(grant), 0);
    src_flag[0] = 1'b0; tick(); src_flag[0] = 1'b1; ticks(2);
    chk("R3 new rise grants", 32'(grant), 32'h1);
    xfer_done[0] = 1'b1; reg_hit[0] = 1'b1; tick();
    chk("R9 clear with reg_hit", 32'(flag_clr), 32'h001);
    xfer_done = '0; reg_hit = '0;

    // R10 R7 shared ownership
    idle();
    cfg(0, 6, 0, 1, 0);
    src_flag[6] = 1'b1; tick();
    chk("R7 shared source forwarded", 32'(cpu_irq), 32'h040);
    tick();
    chk("R10 grant on shared source", 32'(grant), 32'h1);
    xfer_done[0] = 1'b1; tick();
    chk("R10 no clear when not owned", 32'(flag_clr), 0);
    xfer_done = '0; ch_own[0] = 1'b1; tick();
    chk("R7 owned source blocked", 32'(cpu_irq), 0);

    // R6 enable
    idle();
    cfg(0, 7, 0, 0, 1);
    src_flag[7] = 1'b1; ticks(3);
    chk("R6 disabled never granted", 32'(grant), 0);
    chk("R6 disabled source forwarded", 32'(cpu_irq), 32'h080);
    ch_enable[0] = 1'b1; src_flag[7] = 1'b0; tick();
    src_flag[7] = 1'b1; ticks(2);
    chk("R6 enabled grant", 32'(grant), 32'h1);
    ch_enable[0] = 1'b0; tick();
    chk("R6 disable withdraws grant", 32'(grant), 0);
    ch_enable[0] = 1'b1; ticks(2);
    chk("R6 pending dropped", 32'(grant), 0);

    // R12 pin edge
    idle();
    cfg(0, 11, 1, 1, 1);
    dreq_n[0] = 1'b0; ticks(3);
    chk("R12 not yet granted", 32'(grant), 0);
    tick();
    chk("R12 edge grant on fourth edge", 32'(grant), 32'h1);
    xfer_done[0] = 1'b1; tick(); xfer_done = '0; ticks(3);
    chk("R12 one request per edge", 32'(grant), 0);
    dreq_n[0] = 1'b1; ticks(3); dreq_n[0] = 1'b0; ticks(4);
    chk("R12 second edge grants", 32'(grant), 32'h1);
    xfer_done[0] = 1'b1; tick(); xfer_done = '0;

    // R13 pin level
    idle();
    cfg(2, 12, 2, 1, 1);
    dreq_n[1] = 1'b0; ticks(4);
    chk("R13 level grant", 32'(grant), 32'h4);
    xfer_done[2] = 1'b1; tick(); xfer_done = '0;
    chk("R13 released", 32'(grant), 0);
    tick();
    chk("R13 level re-grant", 32'(grant), 32'h4);

    // R14 R5 R4 auto-request
    idle();
    cfg(2, 13, 1, 1, 1); ticks(2);
    chk("R14 auto grant", 32'(grant), 32'h4);
    xfer_done[0] = 1'b1; tick(); xfer_done = '0;
    chk("R5 stray done ignored", 32'(grant), 32'h4);
    cfg(0, 13, 1, 1, 1); tick();
    chk("R4 grant held while higher waits", 32'(grant), 32'h4);
    xfer_done[2] = 1'b1; tick(); xfer_done = '0;
    chk("R4 idle cycle between grants", 32'(grant), 0);
    tick();
    chk("R4 highest priority wins", 32'(grant), 32'h1);

    // constrained random against reference
    idle();
    for (int i = 0; i < 6000; i++) begin
      if (i % 150 == 0)
        for (int c = 0; c < NCH; c++)
          cfg(c, $urandom_range(0, 15), $urandom_range(0, 3),
              $urandom_range(0, 3) != 0, $urandom_range(0, 1));
      for (int s = 0; s < NSRC; s++) if ($urandom_range(0, 7) == 0) src_flag[s] = ~src_flag[s];
      for (int p = 0; p < 2; p++) if ($urandom_range(0, 5) == 0) dreq_n[p] = ~dreq_n[p];
      for (int c = 0; c < NCH; c++) begin
        xfer_done[c] = m_grant[c] ? ($urandom_range(0, 2) == 0) : ($urandom_range(0, 15) == 0);
        reg_hit[c] = $urandom_range(0, 1);
      end
      tick();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule